// File: doc/BRIEF.md
# Speculative Branch-History Register with Snapshot Recovery

This block holds one global branch-direction history register per hardware thread. An indirect-target predictor uses the register to form its index. Each predicted conditional branch shifts its predicted direction into its thread's register straight away, so later lookups on the same path see the speculative history. At the same moment the block stores the register's value from before the shift in a small store, indexed by a branch tag that the caller chooses. The lookup for the branch itself therefore still uses the older history.

When the pipeline learns that work must be undone, it names a tag. A squash of a wrong-path branch puts that branch's stored value back into the register unchanged. A direction misprediction does a little more. It puts back the stored value and shifts in the real outcome in the same cycle, so the history is correct at once and no second update is needed. When a branch retires, its tag is freed and the register is left alone. The register width is a parameter. A width larger than the internal arithmetic word stops elaboration.

Top module: `ghist_recover`

## Requirements
- R1: After reset every thread's history reads zero and every snapshot slot is empty.
- R2: A prediction strobe for thread t makes that thread's history ((old << 1) | taken) cut to HIST_W bits in the next cycle: the taken bit enters at bit 0 and bit HIST_W-1 falls off. Other threads are not changed.
- R3: During a prediction strobe, pred_snap_o shows the named thread's history from before the shift, and that same value is written to the slot named by pred_tag, which becomes valid.
- R4: A restore strobe naming a valid slot makes the named thread's history equal to that slot's value in the next cycle.
- R5: A correction strobe naming a valid slot makes the named thread's history ((slot << 1) | actual) cut to HIST_W bits in the next cycle.
- R6: For one thread in one cycle, a correction takes precedence over a restore, and a restore takes precedence over a prediction shift. Strobes for different threads act independently in the same cycle.
- R7: A commit strobe empties its slot and leaves every history unchanged. A later restore or correction naming that slot has no effect. A prediction and a commit on the same tag in the same cycle leave the slot valid, holding the new value.
- R8: A restore or correction that names a slot never written since reset has no effect on any history.
- R9: Any sequence of updates leaves at most HIST_W significant bits. With HIST_W = 13, a long run of taken shifts settles at 0x1FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | Prediction strobe: shift and take a snapshot |
| pred_thread | input | TID_W (1) | Thread of the prediction |
| pred_taken | input | 1 | Predicted direction (1 = taken) |
| pred_tag | input | TAG_W (4) | Slot that receives the snapshot |
| pred_snap_o | output | HIST_W (13) | History of pred_thread before the shift |
| restore_valid | input | 1 | Squash strobe: reload from a slot |
| restore_thread | input | TID_W (1) | Thread to reload |
| restore_tag | input | TAG_W (4) | Slot to reload from |
| fix_valid | input | 1 | Misprediction strobe: reload then shift in the outcome |
| fix_thread | input | TID_W (1) | Thread to correct |
| fix_tag | input | TAG_W (4) | Slot holding the pre-prediction history |
| fix_taken | input | 1 | Actual direction |
| commit_valid | input | 1 | Retire strobe: free a slot |
| commit_tag | input | TAG_W (4) | Slot to free |
| hist_o | output | NUM_THREADS*HIST_W (26) | All thread histories; thread t sits at bits [t*HIST_W +: HIST_W] |

## Verification
The assertions assume that every strobe, tag and thread selector is a known value on each clock after reset, and that thread selectors stay below NUM_THREADS. The stimulus drives all inputs on every cycle, including during reset. It picks thread numbers only from the existing threads and picks tags from the whole tag range. This lets restores and corrections hit empty, freed and rewritten slots, and lets several strobes coincide on one thread or on one tag.

// File: rtl/ghr_pkg.sv
package ghr_pkg;

    // Width of the word used for shift arithmetic; history widths must fit.
    localparam int unsigned GHR_WORD_W = 32;

    typedef logic [GHR_WORD_W-1:0] ghr_word_t;

    // Which update a thread register takes in a cycle.
    typedef enum logic [1:0] {
        UPD_HOLD    = 2'd0,
        UPD_SHIFT   = 2'd1,
        UPD_RESTORE = 2'd2,
        UPD_FIX     = 2'd3
    } ghr_upd_e;

    function automatic ghr_word_t ghr_mask(input int unsigned width);
        ghr_word_t m;
        if (width >= GHR_WORD_W) begin
            m = '1;
        end else begin
            m = (ghr_word_t'(1) << width) - ghr_word_t'(1);
        end
        return m;
    endfunction

    // Shift one direction bit in at the bottom and trim to width.
    function automatic ghr_word_t ghr_push(input ghr_word_t base,
                                           input logic      dir_bit,
                                           input int unsigned width);
        return ((base << 1) | ghr_word_t'(dir_bit)) & ghr_mask(width);
    endfunction

endpackage

// File: rtl/ghr_snap_store.sv
module ghr_snap_store
    import ghr_pkg::*;
#(
    parameter int unsigned HIST_W = 13,
    parameter int unsigned TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [HIST_W-1:0] wr_data,
    input  logic              clr_en,
    input  logic [TAG_W-1:0]  clr_tag,
    input  logic [TAG_W-1:0]  rd_a_tag,
    output logic [HIST_W-1:0] rd_a_data,
    output logic              rd_a_valid,
    input  logic [TAG_W-1:0]  rd_b_tag,
    output logic [HIST_W-1:0] rd_b_data,
    output logic              rd_b_valid
);

    localparam int unsigned DEPTH = 1 << TAG_W;

    typedef struct packed {
        logic [DEPTH-1:0]             valid;
        logic [DEPTH-1:0][HIST_W-1:0] data;
    } store_t;

    store_t store_d, store_q;

    always_comb begin
        store_d = store_q;
        // Free first so that a same-tag write in this cycle wins.
        if (clr_en) begin
            store_d.valid[clr_tag] = 1'b0;
        end
        if (wr_en) begin
            store_d.valid[wr_tag] = 1'b1;
            store_d.data[wr_tag]  = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            store_q <= store_d;
        end
    end

    assign rd_a_data  = store_q.data[rd_a_tag];
    assign rd_a_valid = store_q.valid[rd_a_tag];
    assign rd_b_data  = store_q.data[rd_b_tag];
    assign rd_b_valid = store_q.valid[rd_b_tag];

    // R3: a written snapshot is held and marked valid in its slot.
    a_r3_snapshot_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (store_q.valid[$past(wr_tag)] &&
                   store_q.data[$past(wr_tag)] == $past(wr_data)));

    // R7: a commit empties its slot unless a write lands on it together.
    a_r7_commit_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(wr_en && wr_tag == clr_tag)) |=> !store_q.valid[$past(clr_tag)]);

endmodule

// File: rtl/ghr_thread.sv
module ghr_thread
    import ghr_pkg::*;
#(
    parameter int unsigned HIST_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    input  logic              restore_en,
    input  logic [HIST_W-1:0] restore_snap,
    input  logic              fix_en,
    input  logic [HIST_W-1:0] fix_snap,
    input  logic              fix_bit,
    output logic [HIST_W-1:0] hist_o
);

    typedef struct packed {
        logic [HIST_W-1:0] hist;
    } thread_state_t;

    thread_state_t st_d, st_q;
    ghr_upd_e      upd_sel;

    always_comb begin
        if (fix_en) begin
            upd_sel = UPD_FIX;
        end else if (restore_en) begin
            upd_sel = UPD_RESTORE;
        end else if (shift_en) begin
            upd_sel = UPD_SHIFT;
        end else begin
            upd_sel = UPD_HOLD;
        end

        st_d = st_q;
        case (upd_sel)
            UPD_FIX:     st_d.hist = HIST_W'(ghr_push(ghr_word_t'(fix_snap), fix_bit, HIST_W));
            UPD_RESTORE: st_d.hist = restore_snap;
            UPD_SHIFT:   st_d.hist = HIST_W'(ghr_push(ghr_word_t'(st_q.hist), shift_bit, HIST_W));
            default:     st_d.hist = st_q.hist;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hist_o = st_q.hist;

    // R2: an uncontested shift moves the old low bits up and inserts the bit.
    a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !restore_en && !fix_en) |=>
            hist_o == {$past(hist_o[HIST_W-2:0]), $past(shift_bit)});

    // R4: a restore without a correction reloads the snapshot as is.
    a_r4_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_en && !fix_en) |=> hist_o == $past(restore_snap));

    // R5 and R6: a correction wins and shifts the outcome onto the snapshot.
    a_r5_fix: assert property (@(posedge clk) disable iff (!rst_n)
        fix_en |=> hist_o == {$past(fix_snap[HIST_W-2:0]), $past(fix_bit)});

    // R7: with no update strobe the history holds.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !restore_en && !fix_en) |=> $stable(hist_o));

endmodule

// File: rtl/ghist_recover.sv
module ghist_recover
    import ghr_pkg::*;
#(
    parameter int unsigned NUM_THREADS = 2,
    parameter int unsigned HIST_W      = 13,
    parameter int unsigned TAG_W       = 4,
    localparam int unsigned TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pred_valid,
    input  logic [TID_W-1:0]              pred_thread,
    input  logic                          pred_taken,
    input  logic [TAG_W-1:0]              pred_tag,
    output logic [HIST_W-1:0]             pred_snap_o,
    input  logic                          restore_valid,
    input  logic [TID_W-1:0]              restore_thread,
    input  logic [TAG_W-1:0]              restore_tag,
    input  logic                          fix_valid,
    input  logic [TID_W-1:0]              fix_thread,
    input  logic [TAG_W-1:0]              fix_tag,
    input  logic                          fix_taken,
    input  logic                          commit_valid,
    input  logic [TAG_W-1:0]              commit_tag,
    output logic [NUM_THREADS*HIST_W-1:0] hist_o
);

    // Reject widths that the shift arithmetic cannot hold.
    if (HIST_W < 2 || HIST_W > GHR_WORD_W) begin : g_bad_width
        $error("ghist_recover: HIST_W must lie between 2 and the arithmetic word width");
    end

    logic [NUM_THREADS-1:0][HIST_W-1:0] hist_w;
    logic [HIST_W-1:0]                  rst_snap_w;
    logic [HIST_W-1:0]                  fix_snap_w;
    logic                               rst_hit_w;
    logic                               fix_hit_w;

    assign pred_snap_o = hist_w[pred_thread];

    ghr_snap_store #(
        .HIST_W (HIST_W),
        .TAG_W  (TAG_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (pred_valid),
        .wr_tag     (pred_tag),
        .wr_data    (pred_snap_o),
        .clr_en     (commit_valid),
        .clr_tag    (commit_tag),
        .rd_a_tag   (restore_tag),
        .rd_a_data  (rst_snap_w),
        .rd_a_valid (rst_hit_w),
        .rd_b_tag   (fix_tag),
        .rd_b_data  (fix_snap_w),
        .rd_b_valid (fix_hit_w)
    );

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
        logic shift_en_w, restore_en_w, fix_en_w;

        assign shift_en_w   = pred_valid && (pred_thread == TID_W'(t));
        assign restore_en_w = restore_valid && rst_hit_w && (restore_thread == TID_W'(t));
        assign fix_en_w     = fix_valid && fix_hit_w && (fix_thread == TID_W'(t));

        ghr_thread #(
            .HIST_W (HIST_W)
        ) u_thread (
            .clk          (clk),
            .rst_n        (rst_n),
            .shift_en     (shift_en_w),
            .shift_bit    (pred_taken),
            .restore_en   (restore_en_w),
            .restore_snap (rst_snap_w),
            .fix_en       (fix_en_w),
            .fix_snap     (fix_snap_w),
            .fix_bit      (fix_taken),
            .hist_o       (hist_w[t])
        );

        assign hist_o[t*HIST_W +: HIST_W] = hist_w[t];
    end

endmodule

// File: tb/ghist_recover_test.sv
module ghist_recover_test;

    localparam int NT = 2;
    localparam int HW = 13;
    localparam int TW = 4;
    localparam int DEPTH = 1 << TW;
    localparam int MASK = (1 << HW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pred_valid = 0, pred_thread = 0, pred_taken = 0;
    logic [TW-1:0] pred_tag = '0;
    logic [HW-1:0] pred_snap_o;
    logic restore_valid = 0, restore_thread = 0;
    logic [TW-1:0] restore_tag = '0;
    logic fix_valid = 0, fix_thread = 0, fix_taken = 0;
    logic [TW-1:0] fix_tag = '0;
    logic commit_valid = 0;
    logic [TW-1:0] commit_tag = '0;
    logic [NT*HW-1:0] hist_o;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";

    int m_hist [NT];
    int m_snap [DEPTH];
    bit m_val  [DEPTH];

    always #2.5 clk = ~clk;

    ghist_recover uut (
        .clk(clk), .rst_n(rst_n),
        .pred_valid(pred_valid), .pred_thread(pred_thread), .pred_taken(pred_taken),
        .pred_tag(pred_tag), .pred_snap_o(pred_snap_o),
        .restore_valid(restore_valid), .restore_thread(restore_thread), .restore_tag(restore_tag),
        .fix_valid(fix_valid), .fix_thread(fix_thread), .fix_tag(fix_tag), .fix_taken(fix_taken),
        .commit_valid(commit_valid), .commit_tag(commit_tag),
        .hist_o(hist_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int hist_of(input int t);
        return int'(hist_o[t*HW +: HW]);
    endfunction

    task automatic idle();
        pred_valid = 0; restore_valid = 0; fix_valid = 0; commit_valid = 0;
    endtask

    // Reference update applied at each rising edge from the inputs in place.
    task automatic model_step();
        int nh [NT];
        for (int t = 0; t < NT; t++) begin
            nh[t] = m_hist[t];
            if (fix_valid && int'(fix_thread) == t && m_val[fix_tag])
                nh[t] = ((m_snap[fix_tag] << 1) | int'(fix_taken)) & MASK;
            else if (restore_valid && int'(restore_thread) == t && m_val[restore_tag])
                nh[t] = m_snap[restore_tag];
            else if (pred_valid && int'(pred_thread) == t)
                nh[t] = ((m_hist[t] << 1) | int'(pred_taken)) & MASK;
        end
        if (commit_valid) m_val[commit_tag] = 1'b0;
        if (pred_valid) begin
            m_val[pred_tag]  = 1'b1;
            m_snap[pred_tag] = m_hist[pred_thread];
        end
        for (int t = 0; t < NT; t++) m_hist[t] = nh[t];
    endtask

    // One cycle: inputs already set after a falling edge.
    task automatic cycle();
        #1;
        if (pred_valid) chk("R3 snapshot", int'(pred_snap_o), m_hist[pred_thread]);
        @(posedge clk);
        model_step();
        @(negedge clk);
        for (int t = 0; t < NT; t++) chk(cur_req, hist_of(t), m_hist[t]);
        idle();
    endtask

    task automatic do_pred(input int t, input int tk, input int tag);
        pred_valid = 1; pred_thread = t[0]; pred_taken = tk[0]; pred_tag = TW'(tag);
    endtask

    task automatic do_restore(input int t, input int tag);
        restore_valid = 1; restore_thread = t[0]; restore_tag = TW'(tag);
    endtask

    task automatic do_fix(input int t, input int tag, input int tk);
        fix_valid = 1; fix_thread = t[0]; fix_tag = TW'(tag); fix_taken = tk[0];
    endtask

    task automatic do_commit(input int tag);
        commit_valid = 1; commit_tag = TW'(tag);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int t = 0; t < NT; t++) m_hist[t] = 0;
        for (int i = 0; i < DEPTH; i++) begin m_snap[i] = 0; m_val[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1", hist_of(0), 0);
        chk("R1", hist_of(1), 0);

        // R8: restore and correction on never-written slots do nothing
        cur_req = "R2";
        do_pred(0, 1, 0); cycle();
        chk("R2", hist_of(0), 1);
        chk("R2", hist_of(1), 0);
        cur_req = "R8";
        do_restore(0, 9); cycle();
        do_fix(0, 10, 1); cycle();
        chk("R8", hist_of(0), 1);

        // R2 and R3: build history 1 -> 2 -> 5
        cur_req = "R2";
        do_pred(0, 0, 1); cycle();
        chk("R2", hist_of(0), 2);
        do_pred(0, 1, 2); cycle();
        chk("R2", hist_of(0), 5);

        // R5: correct the branch at tag 1 (snapshot 1) with outcome taken
        cur_req = "R5";
        do_fix(0, 1, 1); cycle();
        chk("R5", hist_of(0), 3);

        // R4: restore tag 2 (snapshot 2)
        cur_req = "R4";
        do_restore(0, 2); cycle();
        chk("R4", hist_of(0), 2);

        // R7: commit frees tag 2, history holds, then a restore is ignored
        cur_req = "R7";
        do_commit(2); cycle();
        chk("R7", hist_of(0), 2);
        do_pred(0, 1, 3); cycle();
        chk("R7", hist_of(0), 5);
        do_restore(0, 2); cycle();
        chk("R7", hist_of(0), 5);
        // same-tag prediction and commit: slot stays valid with new snapshot 5
        do_pred(0, 0, 4); do_commit(4); cycle();
        do_restore(0, 4); cycle();
        chk("R7", hist_of(0), 5);

        // R6: restore beats shift; correction beats restore; other thread shifts
        cur_req = "R6";
        do_pred(0, 1, 5); do_restore(0, 0); cycle();
        chk("R6", hist_of(0), 0);
        do_restore(0, 0); do_fix(0, 1, 0); do_pred(1, 1, 6); cycle();
        chk("R6", hist_of(0), 2);
        chk("R6", hist_of(1), 1);

        // R9: long taken run saturates at the width mask, correction trims too
        cur_req = "R9";
        for (int i = 0; i < 20; i++) begin do_pred(1, 1, 7); cycle(); end
        chk("R9", hist_of(1), 'h1FFF);
        do_pred(1, 0, 8); cycle();
        chk("R9", hist_of(1), 'h1FFE);
        do_fix(1, 8, 1); cycle();
        chk("R9", hist_of(1), 'h1FFF);

        // R6 mixed random traffic against the model
        cur_req = "R6 random";
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(3) != 0) do_pred($urandom_range(1), $urandom_range(1), $urandom_range(DEPTH-1));
            if ($urandom_range(5) == 0) do_restore($urandom_range(1), $urandom_range(DEPTH-1));
            if ($urandom_range(6) == 0) do_fix($urandom_range(1), $urandom_range(DEPTH-1), $urandom_range(1));
            if ($urandom_range(2) == 0) do_commit($urandom_range(DEPTH-1));
            cycle();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule